// File: doc/BRIEF.md
# High-Speed Chirp Speed Negotiator (Device Side)

This block is the device-side controller that settles whether a link runs at high speed or falls back to full speed when the host side resets the bus. It starts in high-speed operation with its high-speed termination switched on. It watches four line-state indications: single-ended zero, high-speed idle, chirp K and chirp J. If the bus stays idle for long enough, the block attaches as a full-speed device. It then looks at the line a little later to tell a bus reset from a suspend.

On a reset, the block sends a long chirp K of its own. It then counts debounced K-then-J pairs from the upstream port. Once the required number of pairs is seen, it switches back to high-speed termination. If a wait window runs out first, it stays at full speed. A one-cycle completion pulse reports the result together with the speed flag. A device in suspend that sees a steady single-ended zero starts the same chirp sequence. Every input passes through a multi-flop synchronizer before any filtering. Every duration is a parameter counted in clock ticks.

Top module: `hs_chirp_negotiator`

## Requirements
- R1: After synchronous reset, hs_term_en=1, hs_mode=1, fs_pullup_en=0, chirp_k_tx=0, suspended=0 and neg_done=0.
- R2: In high-speed operation, a high-speed idle indication held for T_IDLE consecutive ticks switches the termination off, turns the pull-up on and clears hs_mode. With a two-flop synchronizer, this appears T_IDLE+3 cycles after the input rises. Any non-idle cycle before that restarts the count.
- R3: T_SAMPLE ticks after the fall-back to full speed, the synchronized SE0 input is sampled. SE0 starts the device chirp. Any other line state sets suspended=1, keeps the pull-up on and sends no chirp.
- R4: The device chirp asserts chirp_k_tx for exactly T_CHIRP consecutive ticks. During the chirp, the pull-up is on and the termination is off.
- R5: An upstream chirp K or J counts only when its synchronized input stays high for at least T_FILT consecutive ticks. A shorter pulse is ignored, and the hold count starts again.
- R6: If PAIRS filtered K-then-J pairs arrive before the wait window closes, the block sets hs_term_en=1, fs_pullup_en=0 and hs_mode=1, and gives one neg_done pulse.
- R7: The wait window lasts T_WAIT ticks from the end of the device chirp. If it closes with fewer pairs, the block gives one neg_done pulse with hs_mode=0 and the pull-up on. It then stays at full speed, whatever the line does, until the next reset.
- R8: In suspend, SE0 held for T_FILT consecutive ticks starts the device chirp. A shorter SE0 pulse leaves the block suspended.
- R9: neg_done never stays high for two consecutive cycles, and it pulses once per negotiation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_se0 | input | 1 | Single-ended zero seen on the line |
| bus_hs_idle | input | 1 | No high-speed activity (squelch) |
| bus_chirp_k | input | 1 | Chirp K from the upstream port |
| bus_chirp_j | input | 1 | Chirp J (or full-speed J) on the line |
| hs_term_en | output | 1 | High-speed termination enable |
| fs_pullup_en | output | 1 | Full-speed D+ pull-up enable |
| chirp_k_tx | output | 1 | Request to drive chirp K |
| hs_mode | output | 1 | Negotiated speed: 1 high speed, 0 full speed |
| suspended | output | 1 | Line was found idle in J after fall-back |
| neg_done | output | 1 | One-cycle pulse when negotiation ends |

## Verification
The hardest case to reach from the ports is a pair count that sits right at the edge of the debounce. A K lasting exactly T_FILT ticks must count, and one lasting T_FILT-1 must not. This is hard because the synchronizer and hold counter put several cycles between each port edge and the state change. Directed trials drive chirps of exactly those widths, so the result flips between high speed and full speed on the boundary. Random trials then mix good pairs with short K glitches in varied numbers and widths. Separate sequences push the block into suspend and back out through a reset.

// File: rtl/hsneg_pkg.sv
package hsneg_pkg;
   typedef enum logic [2:0] {
      ST_HS_RUN  = 3'd0,
      ST_REVERT  = 3'd1,
      ST_SUSPEND = 3'd2,
      ST_CHIRP   = 3'd3,
      ST_HUB_K   = 3'd4,
      ST_HUB_J   = 3'd5,
      ST_FS_DONE = 3'd6
   } neg_state_e;

   // bit positions inside the synchronized line vector
   localparam int LINE_W  = 4;
   localparam int LN_SE0  = 0;
   localparam int LN_IDLE = 1;
   localparam int LN_K    = 2;
   localparam int LN_J    = 3;

   function automatic logic in_hub_phase(neg_state_e s);
      return (s == ST_HUB_K) || (s == ST_HUB_J);
   endfunction
endpackage

// File: rtl/hsneg_sync.sv
module hsneg_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         logic [STAGES-1:0] stg;
         always_ff @(posedge clk) begin
            if (rst) stg <= '0;
            else     stg <= {stg[STAGES-2:0], d[b]};
         end
         assign q[b] = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hsneg_hold.sv
module hsneg_hold #(
   parameter int HOLD = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic lvl,
   output logic held
);
   localparam int CW = $clog2(HOLD + 1);
   localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || !(en && lvl)) cnt <= '0;
      else if (cnt != HOLD_C)  cnt <= cnt + 1'b1;
   end

   assign held = en && (cnt == HOLD_C);
endmodule

// File: rtl/hsneg_fsm.sv
module hsneg_fsm
   import hsneg_pkg::*;
#(
   parameter int T_SAMPLE = 20,
   parameter int T_CHIRP  = 30,
   parameter int T_WAIT   = 300,
   parameter int PAIRS    = 3
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       se0_now,
   input  logic       idle_held,
   input  logic       se0_held,
   input  logic       k_held,
   input  logic       j_held,
   output neg_state_e state,
   output logic       done
);
   localparam int TMAX = (T_SAMPLE > T_CHIRP) ?
                         ((T_SAMPLE > T_WAIT) ? T_SAMPLE : T_WAIT) :
                         ((T_CHIRP  > T_WAIT) ? T_CHIRP  : T_WAIT);
   localparam int TW = $clog2(TMAX + 1);
   localparam int PW = $clog2(PAIRS + 1);
   localparam logic [TW-1:0] SAMPLE_END = TW'(T_SAMPLE - 1);
   localparam logic [TW-1:0] CHIRP_END  = TW'(T_CHIRP - 1);
   localparam logic [TW-1:0] WAIT_END   = TW'(T_WAIT - 1);
   localparam logic [PW-1:0] LAST_PAIR  = PW'(PAIRS - 1);

   neg_state_e state_q, state_d;
   logic [TW-1:0] tmr_q;
   logic [PW-1:0] pairs_q;
   logic          pairs_clr, pairs_inc, tmr_run, tmr_clr, finish;

   always_comb begin
      state_d   = state_q;
      pairs_clr = 1'b0;
      pairs_inc = 1'b0;
      finish    = 1'b0;
      unique case (state_q)
         ST_HS_RUN: begin
            if (idle_held) state_d = ST_REVERT;
         end
         ST_REVERT: begin
            if (tmr_q == SAMPLE_END) state_d = se0_now ? ST_CHIRP : ST_SUSPEND;
         end
         ST_SUSPEND: begin
            if (se0_held) state_d = ST_CHIRP;
         end
         ST_CHIRP: begin
            if (tmr_q == CHIRP_END) begin
               state_d   = ST_HUB_K;
               pairs_clr = 1'b1;
            end
         end
         ST_HUB_K: begin
            if (tmr_q == WAIT_END) begin
               state_d = ST_FS_DONE;
               finish  = 1'b1;
            end else if (k_held) begin
               state_d = ST_HUB_J;
            end
         end
         ST_HUB_J: begin
            if (j_held && (pairs_q == LAST_PAIR)) begin
               state_d = ST_HS_RUN;
               finish  = 1'b1;
            end else if (tmr_q == WAIT_END) begin
               state_d = ST_FS_DONE;
               finish  = 1'b1;
            end else if (j_held) begin
               state_d   = ST_HUB_K;
               pairs_inc = 1'b1;
            end
         end
         ST_FS_DONE: state_d = ST_FS_DONE;
         default:    state_d = ST_HS_RUN;
      endcase
   end

   assign tmr_run = (state_q == ST_REVERT) || (state_q == ST_CHIRP) || in_hub_phase(state_q);
   assign tmr_clr = (state_d != state_q) && !(in_hub_phase(state_d) && in_hub_phase(state_q));

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_HS_RUN;
         tmr_q   <= '0;
         pairs_q <= '0;
         done    <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= finish;
         if (tmr_clr)      tmr_q <= '0;
         else if (tmr_run) tmr_q <= tmr_q + 1'b1;
         if (pairs_clr)      pairs_q <= '0;
         else if (pairs_inc) pairs_q <= pairs_q + 1'b1;
      end
   end

   assign state = state_q;
endmodule

// File: rtl/hs_chirp_negotiator.sv
module hs_chirp_negotiator
   import hsneg_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int T_IDLE      = 375000,
   parameter int T_SAMPLE    = 60000,
   parameter int T_CHIRP     = 150000,
   parameter int T_FILT      = 300,
   parameter int T_WAIT      = 180000,
   parameter int PAIRS       = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic bus_se0,
   input  logic bus_hs_idle,
   input  logic bus_chirp_k,
   input  logic bus_chirp_j,
   output logic hs_term_en,
   output logic fs_pullup_en,
   output logic chirp_k_tx,
   output logic hs_mode,
   output logic suspended,
   output logic neg_done
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hs_chirp_negotiator: SYNC_STAGES must be at least 2");
      end
      if (T_FILT < 1 || T_CHIRP < 1 || T_SAMPLE < 1 || T_IDLE < 1) begin : g_bad_time
         $error("hs_chirp_negotiator: every duration must be at least one tick");
      end
      if (PAIRS < 1) begin : g_bad_pairs
         $error("hs_chirp_negotiator: PAIRS must be at least 1");
      end
      if (T_WAIT <= 2 * PAIRS * T_FILT) begin : g_bad_wait
         $error("hs_chirp_negotiator: T_WAIT too short to collect PAIRS filtered pairs");
      end
   endgenerate

   logic [LINE_W-1:0] line_raw, line_s, flt_en, flt_held;
   neg_state_e        state;

   assign line_raw[LN_SE0]  = bus_se0;
   assign line_raw[LN_IDLE] = bus_hs_idle;
   assign line_raw[LN_K]    = bus_chirp_k;
   assign line_raw[LN_J]    = bus_chirp_j;

   hsneg_sync #(.W(LINE_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk (clk),
      .rst (rst),
      .d   (line_raw),
      .q   (line_s)
   );

   assign flt_en[LN_SE0]  = (state == ST_SUSPEND);
   assign flt_en[LN_IDLE] = (state == ST_HS_RUN);
   assign flt_en[LN_K]    = (state == ST_HUB_K);
   assign flt_en[LN_J]    = (state == ST_HUB_J);

   generate
      for (genvar b = 0; b < LINE_W; b++) begin : g_flt
         localparam int HOLD_B = (b == LN_IDLE) ? T_IDLE : T_FILT;
         hsneg_hold #(.HOLD(HOLD_B)) hold_i (
            .clk  (clk),
            .rst  (rst),
            .en   (flt_en[b]),
            .lvl  (line_s[b]),
            .held (flt_held[b])
         );
      end
   endgenerate

   hsneg_fsm #(
      .T_SAMPLE (T_SAMPLE),
      .T_CHIRP  (T_CHIRP),
      .T_WAIT   (T_WAIT),
      .PAIRS    (PAIRS)
   ) fsm_i (
      .clk       (clk),
      .rst       (rst),
      .se0_now   (line_s[LN_SE0]),
      .idle_held (flt_held[LN_IDLE]),
      .se0_held  (flt_held[LN_SE0]),
      .k_held    (flt_held[LN_K]),
      .j_held    (flt_held[LN_J]),
      .state     (state),
      .done      (neg_done)
   );

   assign hs_term_en   = (state == ST_HS_RUN);
   assign hs_mode      = (state == ST_HS_RUN);
   assign fs_pullup_en = (state != ST_HS_RUN);
   assign chirp_k_tx   = (state == ST_CHIRP);
   assign suspended    = (state == ST_SUSPEND);
endmodule

// File: rtl/hsneg_checker.sv
module hsneg_checker #(
   parameter int T_CHIRP = 30
) (
   input logic clk,
   input logic rst,
   input logic hs_term_en,
   input logic fs_pullup_en,
   input logic chirp_k_tx,
   input logic hs_mode,
   input logic suspended,
   input logic neg_done
);
   int clen;

   always_ff @(posedge clk) begin
      if (rst || !chirp_k_tx) clen <= 0;
      else                    clen <= clen + 1;
   end

   assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
      neg_done |=> !neg_done);

   assert_hs_attach_R6: assert property (@(posedge clk) disable iff (rst)
      (neg_done && hs_mode) |-> (hs_term_en && !fs_pullup_en));

   assert_fs_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (neg_done && !hs_mode) |=> (fs_pullup_en && !hs_mode && !hs_term_en));

   assert_chirp_len_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(chirp_k_tx) |-> (clen == T_CHIRP));

   assert_revert_attach_R2: assert property (@(posedge clk) disable iff (rst)
      $fell(hs_term_en) |-> (fs_pullup_en && !hs_mode));

   assert_suspend_quiet_R3: assert property (@(posedge clk) disable iff (rst)
      suspended |-> (!chirp_k_tx && fs_pullup_en && !neg_done));
endmodule

bind hs_chirp_negotiator hsneg_checker #(.T_CHIRP(T_CHIRP)) chk_i (
   .clk          (clk),
   .rst          (rst),
   .hs_term_en   (hs_term_en),
   .fs_pullup_en (fs_pullup_en),
   .chirp_k_tx   (chirp_k_tx),
   .hs_mode      (hs_mode),
   .suspended    (suspended),
   .neg_done     (neg_done)
);

// File: tb/hs_chirp_negotiator_tb_top.sv
module hs_chirp_negotiator_tb_top;
   localparam int T_IDLE   = 40;
   localparam int T_SAMPLE = 20;
   localparam int T_CHIRP  = 30;
   localparam int T_FILT   = 4;
   localparam int T_WAIT   = 300;
   localparam int PAIRS    = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bus_se0 = 1'b0, bus_hs_idle = 1'b0, bus_chirp_k = 1'b0, bus_chirp_j = 1'b0;
   logic hs_term_en, fs_pullup_en, chirp_k_tx, hs_mode, suspended, neg_done;

   always #2 clk = ~clk;

   hs_chirp_negotiator #(
      .SYNC_STAGES (2),
      .T_IDLE      (T_IDLE),
      .T_SAMPLE    (T_SAMPLE),
      .T_CHIRP     (T_CHIRP),
      .T_FILT      (T_FILT),
      .T_WAIT      (T_WAIT),
      .PAIRS       (PAIRS)
   ) dut_i (
      .clk          (clk),
      .rst          (rst),
      .bus_se0      (bus_se0),
      .bus_hs_idle  (bus_hs_idle),
      .bus_chirp_k  (bus_chirp_k),
      .bus_chirp_j  (bus_chirp_j),
      .hs_term_en   (hs_term_en),
      .fs_pullup_en (fs_pullup_en),
      .chirp_k_tx   (chirp_k_tx),
      .hs_mode      (hs_mode),
      .suspended    (suspended),
      .neg_done     (neg_done)
   );

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;
   logic done_hs = 1'b0;

   always @(negedge clk) begin
      if (!rst && neg_done) begin
         done_cnt++;
         done_hs = hs_mode;
      end
   end

   function automatic logic exp_hs(int good_pairs);
      return good_pairs >= PAIRS;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic se0, input logic idle, input logic k, input logic j, input int n);
      bus_se0 = se0; bus_hs_idle = idle; bus_chirp_k = k; bus_chirp_j = j;
      repeat (n) @(negedge clk);
   endtask

   task automatic apply_reset();
      rst = 1'b1;
      drive(0, 0, 0, 0, 3);
      rst = 1'b0;
      done_cnt = 0;
   endtask

   task automatic wait_chirp(string req);
      int guard = 0;
      int len = 0;
      while (!chirp_k_tx && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      chk({req, " chirp started"}, int'(chirp_k_tx), 1);
      chk("R4 pull-up on during chirp", int'(fs_pullup_en), 1);
      chk("R4 termination off during chirp", int'(hs_term_en), 0);
      while (chirp_k_tx && len < 2000) begin
         @(negedge clk);
         len++;
      end
      chk("R4 chirp length", len, T_CHIRP);
   endtask

   task automatic hub_pair(input int kw, input int jw, input logic glitch);
      if (glitch) begin
         drive(0, 0, 1, 0, $urandom_range(1, T_FILT - 1));
         drive(1, 0, 0, 0, 1);
      end
      drive(0, 0, 1, 0, kw);
      drive(1, 0, 0, 0, 1);
      drive(0, 0, 0, 1, jw);
      drive(1, 0, 0, 0, 1);
   endtask

   task automatic finish_trial(string req, input logic exp);
      drive(0, 0, 0, 0, T_WAIT + 20);
      chk({req, " single done pulse (R9)"}, done_cnt, 1);
      chk({req, " speed at done"}, int'(done_hs), int'(exp));
      chk({req, " hs_mode"}, int'(hs_mode), int'(exp));
      chk({req, " pull-up"}, int'(fs_pullup_en), int'(!exp));
      chk({req, " termination"}, int'(hs_term_en), int'(exp));
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      @(negedge clk);
      apply_reset();

      // R1 reset state
      chk("R1 hs_term_en", int'(hs_term_en), 1);
      chk("R1 hs_mode", int'(hs_mode), 1);
      chk("R1 fs_pullup_en", int'(fs_pullup_en), 0);
      chk("R1 chirp_k_tx", int'(chirp_k_tx), 0);
      chk("R1 suspended", int'(suspended), 0);
      chk("R1 neg_done", int'(neg_done), 0);

      // R2 idle interrupted before the limit: no fall-back
      drive(1, 1, 0, 0, T_IDLE - 2);
      drive(0, 0, 0, 0, 1);
      drive(1, 1, 0, 0, T_IDLE - 2);
      chk("R2 interrupted idle keeps termination", int'(hs_term_en), 1);
      drive(0, 0, 0, 0, 3);

      // R2 exact fall-back latency
      drive(1, 1, 0, 0, T_IDLE + 2);
      chk("R2 termination before limit", int'(hs_term_en), 1);
      drive(1, 1, 0, 0, 1);
      chk("R2 termination after limit", int'(hs_term_en), 0);
      chk("R2 pull-up after limit", int'(fs_pullup_en), 1);
      chk("R2 hs_mode after limit", int'(hs_mode), 0);

      // R3 SE0 at sample time -> chirp; R5 pairs of exactly T_FILT count
      wait_chirp("R3");
      for (int p = 0; p < PAIRS; p++) hub_pair(T_FILT, T_FILT, 1'b0);
      finish_trial("R6 boundary pairs", 1'b1);

      // R5 first K one tick short -> only PAIRS-1 counted -> full speed (R7)
      apply_reset();
      drive(1, 1, 0, 0, 0);
      wait_chirp("R3");
      hub_pair(T_FILT - 1, T_FILT, 1'b0);
      for (int p = 1; p < PAIRS; p++) hub_pair(T_FILT, T_FILT, 1'b0);
      finish_trial("R5 short K ignored, R7 timeout", 1'b0);
      drive(1, 1, 0, 0, 2 * T_IDLE);
      drive(1, 0, 0, 0, T_CHIRP);
      chk("R7 stays full speed hs_mode", int'(hs_mode), 0);
      chk("R7 stays full speed no chirp", int'(chirp_k_tx), 0);
      chk("R7 stays full speed pull-up", int'(fs_pullup_en), 1);

      // R3 suspend, R8 short SE0 ignored, then reset from suspend
      apply_reset();
      drive(1, 1, 0, 0, T_IDLE + 3 + T_SAMPLE / 2);
      drive(0, 0, 0, 1, T_SAMPLE + 4);
      chk("R3 suspended", int'(suspended), 1);
      chk("R3 suspend pull-up", int'(fs_pullup_en), 1);
      chk("R3 suspend no chirp", int'(chirp_k_tx), 0);
      chk("R3 suspend no done", done_cnt, 0);
      drive(1, 0, 0, 0, T_FILT - 1);
      drive(0, 0, 0, 1, 8);
      chk("R8 short SE0 keeps suspend", int'(suspended), 1);
      chk("R8 short SE0 no chirp", int'(chirp_k_tx), 0);
      drive(1, 0, 0, 0, 0);
      wait_chirp("R8");
      for (int p = 0; p < PAIRS; p++) hub_pair(T_FILT + 2, T_FILT + 3, 1'b1);
      finish_trial("R8 wake then R6", 1'b1);

      // Random trials: good pairs with glitches, R5 R6 R7
      for (int t = 0; t < 12; t++) begin
         int good;
         good = $urandom_range(0, PAIRS + 1);
         apply_reset();
         drive(1, 1, 0, 0, 0);
         wait_chirp("R3");
         for (int p = 0; p < good; p++)
            hub_pair($urandom_range(T_FILT, T_FILT + 8), $urandom_range(T_FILT, T_FILT + 8),
                     1'($urandom_range(0, 1)));
         finish_trial("R6/R7 random", exp_hs(good));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule